// File: doc/BRIEF.md
# Cache Line Flush Controller

This block sequences flush and maintenance operations over the tag array of a set-associative write-back cache. Software writes one of two command words. The address command names a line by memory address, or it selects the whole cache. The set/way command names a line by set index and way, or it selects a whole way for maintenance. The block walks the chosen lines one at a time. For each line it clears valid and dirty state, or it loads new tag, valid and dirty values. It issues a write-back request for each dirty line and, when asked, a line fetch request. These go out on a request/acknowledge memory port. A disable bit in either command word produces a one-cycle pulse that clears the cache-enable flag held elsewhere.

The tag array sits inside the block. Each way is a memory with one write port and two registered read ports, so block RAM can be inferred. The cache writes entries through a fill port and reads them back through a look port. The sequencer owns the array while a flush is in progress.

Top module: `cache_flush_ctrl`

## Requirements
- R1: After reset, busy, mem_req and cache_en_clr are low. When idle, a fill write stores {tag, valid, dirty} at (set, way). The look port returns that entry one cycle after look_set/look_way are presented.
- R2: Address command, mode bits 2:0 equal to 001, 010 or 011, acts on one line. The set is address bits LINE_W+SET_W-1:LINE_W (9:5 by default). The way is the valid way whose tag equals address bits 31:LINE_W+SET_W. Mode bit 0 invalidates the line (valid and dirty cleared). Mode bit 1 writes it back if dirty, clearing dirty and keeping valid.
- R3: If no valid way in the addressed set matches the tag, an address single-line command changes no line and issues no request.
- R4: Address modes 101, 110 and 111 apply the same actions to every line. Sets are visited in ascending order, and ways in ascending order within a set.
- R5: A write-back request (mem_wr=1) is issued only for a line that is valid and dirty. Its address is {line tag, set, LINE_W zero bits}. Clean lines cause no request.
- R6: Set/way command with bit 2 clear is a line flush. The set comes from bits 16+SET_W-1:16 and the way from bits 5:4. Mode bits 1:0 work as follows: 01 invalidates, 10 writes back if dirty, 11 does both.
- R7: Set/way command with bit 2 set and mode 01 writes, into every set of the selected way, the tag from bits 31:32-TAG_W, valid from bit 8 and dirty from bit 7. No request is issued.
- R8: Way mode 10 writes back every dirty line of the selected way. Way mode 11 writes back the old dirty content of each line first, then loads the new values of R7.
- R9: With bit 9 set in a way command, each line of the way is followed by a fetch request (mem_wr=0). The fetch address uses the line's tag after its update.
- R10: mem_req stays high with a stable address and direction until mem_ack. The valid and dirty bits of a line being written back change only after that write-back is acknowledged.
- R11: busy is high from the cycle after an accepted command until the last line is done. While busy, commands and fill writes are ignored.
- R12: Address modes 000 and 100, and set/way mode 00 (either value of bit 2), do nothing. busy stays low and no request is issued.
- R13: A 1 in bit 3 of either command write gives cache_en_clr high for exactly the next cycle. This happens for any mode and also while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_cmd_we | input | 1 | Write strobe, address command |
| addr_cmd_data | input | ADDR_W | Address command word |
| set_cmd_we | input | 1 | Write strobe, set/way command (lower priority) |
| set_cmd_data | input | ADDR_W | Set/way command word |
| fill_we | input | 1 | Tag array write from the cache |
| fill_set | input | SET_W | Fill set index |
| fill_way | input | log2(WAYS) | Fill way |
| fill_tag | input | TAG_W | Fill tag |
| fill_valid | input | 1 | Fill valid bit |
| fill_dirty | input | 1 | Fill dirty bit |
| look_set | input | SET_W | Read-back set index |
| look_way | input | log2(WAYS) | Read-back way |
| look_tag | output | TAG_W | Read-back tag |
| look_valid | output | 1 | Read-back valid bit |
| look_dirty | output | 1 | Read-back dirty bit |
| busy | output | 1 | Flush in progress |
| cache_en_clr | output | 1 | One-cycle cache-enable clear pulse |
| mem_req | output | 1 | Memory request |
| mem_wr | output | 1 | 1 for write-back, 0 for line fetch |
| mem_addr | output | ADDR_W | Line address of the request |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Some properties are checked on every cycle: a request holds its address until acknowledged, a write-back only ever targets a valid dirty line, a line under write-back is rewritten only after the acknowledge, fetches come only from way commands, and requests occur only while busy. Other behaviour is visible only through the bench's scenarios. This covers the order of all-cache write-backs, tag-compare misses, which way field is honoured, the values loaded by way maintenance, reserved modes having no effect, and commands or fills being dropped while busy.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [1:0] {
    JOB_LINE = 2'd0,
    JOB_ADDR = 2'd1,
    JOB_WAY  = 2'd2,
    JOB_ALL  = 2'd3
  } job_kind_e;

  typedef struct packed {
    logic inv;
    logic wb;
    logic load;
    logic fetch;
  } job_act_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD    = 3'd1,
    S_EVAL  = 3'd2,
    S_WB    = 3'd3,
    S_WR    = 3'd4,
    S_FETCH = 3'd5,
    S_NEXT  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/flush_tag_way.sv
module flush_tag_way #(
  parameter int SET_W = 5,
  parameter int ENT_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SET_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [SET_W-1:0] raddr_a,
  output logic [ENT_W-1:0] rdata_a,
  input  logic [SET_W-1:0] raddr_b,
  output logic [ENT_W-1:0] rdata_b
);
  localparam int NSETS = 1 << SET_W;

  logic [ENT_W-1:0] mem [NSETS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/flush_cmd_decode.sv
module flush_cmd_decode import flush_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 5,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic                  addr_we,
  input  logic [ADDR_W-1:0]     addr_data,
  input  logic                  set_we,
  input  logic [ADDR_W-1:0]     set_data,
  output logic                  start,
  output job_kind_e             kind,
  output job_act_t              act,
  output logic [SET_W-1:0]      set_o,
  output logic [$clog2(WAYS)-1:0] way_o,
  output logic [ADDR_W-LINE_W-SET_W-1:0] tag_o,
  output logic                  v_o,
  output logic                  d_o,
  output logic                  dis
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - LINE_W - SET_W;
  localparam int IDX_LO = 16;
  localparam int WAY_LO = 4;

  always_comb begin
    start = 1'b0;
    kind  = JOB_LINE;
    act   = '0;
    set_o = '0;
    way_o = '0;
    tag_o = '0;
    v_o   = 1'b0;
    d_o   = 1'b0;
    dis   = (addr_we & addr_data[3]) | (set_we & set_data[3]);
    if (addr_we) begin
      if (addr_data[1:0] != 2'b00) begin
        start   = 1'b1;
        kind    = addr_data[2] ? JOB_ALL : JOB_ADDR;
        act.inv = addr_data[0];
        act.wb  = addr_data[1];
        set_o   = addr_data[LINE_W +: SET_W];
        tag_o   = addr_data[ADDR_W-1 -: TAG_W];
      end
    end else if (set_we) begin
      if (set_data[1:0] != 2'b00) begin
        start = 1'b1;
        way_o = set_data[WAY_LO +: WAY_W];
        if (set_data[2]) begin
          kind      = JOB_WAY;
          act.load  = set_data[0];
          act.wb    = set_data[1];
          act.fetch = set_data[9];
          tag_o     = set_data[ADDR_W-1 -: TAG_W];
          v_o       = set_data[8];
          d_o       = set_data[7];
        end else begin
          kind    = JOB_LINE;
          act.inv = set_data[0];
          act.wb  = set_data[1];
          set_o   = set_data[IDX_LO +: SET_W];
        end
      end
    end
  end
endmodule

// File: rtl/flush_seq.sv
module flush_seq import flush_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 5,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  job_kind_e               kind,
  input  job_act_t                act,
  input  logic [SET_W-1:0]        cset,
  input  logic [$clog2(WAYS)-1:0] cway,
  input  logic [ADDR_W-LINE_W-SET_W-1:0] ctag,
  input  logic                    cv,
  input  logic                    cd,
  input  logic [WAYS*(ADDR_W-LINE_W-SET_W+2)-1:0] rd_lines,
  output logic [SET_W-1:0]        rset,
  output logic                    wr_en,
  output logic [SET_W-1:0]        wr_set,
  output logic [$clog2(WAYS)-1:0] wr_way,
  output logic [ADDR_W-LINE_W-SET_W+1:0] wr_ent,
  output logic                    busy,
  output logic                    mem_req,
  output logic                    mem_wr,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_ack
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - LINE_W - SET_W;
  localparam int ENT_W = TAG_W + 2;
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);
  localparam logic [SET_W-1:0] SET_MAX = '1;

  seq_state_e        state_q;
  job_kind_e         kind_q;
  job_act_t          act_q;
  logic [SET_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic [TAG_W-1:0]  tag_q;
  logic              v_q, d_q;
  logic [ENT_W-1:0]  line_q;
  logic              mreq_q, mwr_q;
  logic [ADDR_W-1:0] maddr_q;

  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  sel_way;
  logic [ENT_W-1:0]  sel_ent;
  logic [TAG_W-1:0]  new_tag;
  logic              last_line;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_lines[w*ENT_W + ENT_W - 1] &&
                   (rd_lines[w*ENT_W +: TAG_W] == tag_q);
    end
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign sel_way = (kind_q == JOB_ADDR) ? hit_way : way_q;
  assign sel_ent = rd_lines[int'(sel_way)*ENT_W +: ENT_W];
  assign new_tag = act_q.load ? tag_q : line_q[TAG_W-1:0];

  always_comb begin
    if (act_q.load)      wr_ent = {v_q, d_q, tag_q};
    else if (act_q.inv)  wr_ent = {2'b00, line_q[TAG_W-1:0]};
    else if (act_q.wb)   wr_ent = {line_q[ENT_W-1], 1'b0, line_q[TAG_W-1:0]};
    else                 wr_ent = line_q;
  end

  always_comb begin
    case (kind_q)
      JOB_ALL: last_line = (set_q == SET_MAX) && (way_q == WAY_MAX);
      JOB_WAY: last_line = (set_q == SET_MAX);
      default: last_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      kind_q  <= JOB_LINE;
      act_q   <= '0;
      set_q   <= '0;
      way_q   <= '0;
      tag_q   <= '0;
      v_q     <= 1'b0;
      d_q     <= 1'b0;
      line_q  <= '0;
      mreq_q  <= 1'b0;
      mwr_q   <= 1'b0;
      maddr_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          kind_q  <= kind;
          act_q   <= act;
          tag_q   <= ctag;
          v_q     <= cv;
          d_q     <= cd;
          set_q   <= (kind == JOB_ALL || kind == JOB_WAY) ? '0 : cset;
          way_q   <= (kind == JOB_LINE || kind == JOB_WAY) ? cway : '0;
          state_q <= S_RD;
        end
        S_RD: state_q <= S_EVAL;
        S_EVAL: begin
          line_q <= sel_ent;
          way_q  <= sel_way;
          if (kind_q == JOB_ADDR && hit_vec == '0) begin
            state_q <= S_NEXT;
          end else if (act_q.wb && sel_ent[ENT_W-1] && sel_ent[ENT_W-2]) begin
            mreq_q  <= 1'b1;
            mwr_q   <= 1'b1;
            maddr_q <= {sel_ent[TAG_W-1:0], set_q, {LINE_W{1'b0}}};
            state_q <= S_WB;
          end else begin
            state_q <= S_WR;
          end
        end
        S_WB: if (mem_ack) begin
          mreq_q  <= 1'b0;
          state_q <= S_WR;
        end
        S_WR: begin
          if (act_q.fetch) begin
            mreq_q  <= 1'b1;
            mwr_q   <= 1'b0;
            maddr_q <= {new_tag, set_q, {LINE_W{1'b0}}};
            state_q <= S_FETCH;
          end else begin
            state_q <= S_NEXT;
          end
        end
        S_FETCH: if (mem_ack) begin
          mreq_q  <= 1'b0;
          state_q <= S_NEXT;
        end
        S_NEXT: begin
          if (last_line) begin
            state_q <= S_IDLE;
          end else begin
            if (kind_q == JOB_ALL) begin
              if (way_q == WAY_MAX) begin
                way_q <= '0;
                set_q <= set_q + 1'b1;
              end else begin
                way_q <= way_q + 1'b1;
              end
            end else begin
              set_q <= set_q + 1'b1;
            end
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rset     = set_q;
  assign wr_en    = (state_q == S_WR);
  assign wr_set   = set_q;
  assign wr_way   = way_q;
  assign busy     = (state_q != S_IDLE);
  assign mem_req  = mreq_q;
  assign mem_wr   = mwr_q;
  assign mem_addr = maddr_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mreq_q && !mem_ack) |=> (mreq_q && $stable(maddr_q) && $stable(mwr_q))); // R10

  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && act_q.wb && line_q[ENT_W-1] && line_q[ENT_W-2]) |-> $past(mem_ack)); // R10

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (mreq_q && mwr_q) |-> (line_q[ENT_W-1] && line_q[ENT_W-2])); // R5

  AST_FETCH_WAY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mreq_q && !mwr_q) |-> (kind_q == JOB_WAY && act_q.fetch)); // R9

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mreq_q |-> (state_q != S_IDLE)); // R11
endmodule

// File: rtl/cache_flush_ctrl.sv
module cache_flush_ctrl import flush_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 5,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          addr_cmd_we,
  input  logic [ADDR_W-1:0]             addr_cmd_data,
  input  logic                          set_cmd_we,
  input  logic [ADDR_W-1:0]             set_cmd_data,
  input  logic                          fill_we,
  input  logic [SET_W-1:0]              fill_set,
  input  logic [$clog2(WAYS)-1:0]       fill_way,
  input  logic [ADDR_W-LINE_W-SET_W-1:0] fill_tag,
  input  logic                          fill_valid,
  input  logic                          fill_dirty,
  input  logic [SET_W-1:0]              look_set,
  input  logic [$clog2(WAYS)-1:0]       look_way,
  output logic [ADDR_W-LINE_W-SET_W-1:0] look_tag,
  output logic                          look_valid,
  output logic                          look_dirty,
  output logic                          busy,
  output logic                          cache_en_clr,
  output logic                          mem_req,
  output logic                          mem_wr,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_ack
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - LINE_W - SET_W;
  localparam int ENT_W = TAG_W + 2;

  logic             dec_start, dec_v, dec_d, dec_dis;
  job_kind_e        dec_kind;
  job_act_t         dec_act;
  logic [SET_W-1:0] dec_set;
  logic [WAY_W-1:0] dec_way;
  logic [TAG_W-1:0] dec_tag;

  logic [WAYS*ENT_W-1:0] rd_lines;
  logic [WAYS*ENT_W-1:0] look_lines;
  logic [SET_W-1:0]      seq_rset, seq_wset;
  logic                  seq_we;
  logic [WAY_W-1:0]      seq_wway;
  logic [ENT_W-1:0]      seq_went;

  logic                  fill_ok;
  logic [SET_W-1:0]      ram_wset;
  logic [WAY_W-1:0]      ram_wway;
  logic [ENT_W-1:0]      ram_went;
  logic                  dis_q;
  logic [WAY_W-1:0]      look_way_q;
  logic [ENT_W-1:0]      look_ent;

  flush_cmd_decode #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W), .WAYS(WAYS)) u_dec (
    .addr_we(addr_cmd_we), .addr_data(addr_cmd_data),
    .set_we(set_cmd_we),   .set_data(set_cmd_data),
    .start(dec_start), .kind(dec_kind), .act(dec_act),
    .set_o(dec_set), .way_o(dec_way), .tag_o(dec_tag),
    .v_o(dec_v), .d_o(dec_d), .dis(dec_dis)
  );

  flush_seq #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W), .WAYS(WAYS)) u_seq (
    .clk(clk), .rst(rst),
    .start(dec_start), .kind(dec_kind), .act(dec_act),
    .cset(dec_set), .cway(dec_way), .ctag(dec_tag), .cv(dec_v), .cd(dec_d),
    .rd_lines(rd_lines), .rset(seq_rset),
    .wr_en(seq_we), .wr_set(seq_wset), .wr_way(seq_wway), .wr_ent(seq_went),
    .busy(busy), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_ack(mem_ack)
  );

  assign fill_ok  = fill_we && !busy;
  assign ram_wset = seq_we ? seq_wset : fill_set;
  assign ram_wway = seq_we ? seq_wway : fill_way;
  assign ram_went = seq_we ? seq_went : {fill_valid, fill_dirty, fill_tag};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = (seq_we || fill_ok) && (ram_wway == WAY_W'(w));
    flush_tag_way #(.SET_W(SET_W), .ENT_W(ENT_W)) u_ram (
      .clk(clk), .we(way_we), .waddr(ram_wset), .wdata(ram_went),
      .raddr_a(seq_rset), .rdata_a(rd_lines[w*ENT_W +: ENT_W]),
      .raddr_b(look_set), .rdata_b(look_lines[w*ENT_W +: ENT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q      <= 1'b0;
      look_way_q <= '0;
    end else begin
      dis_q      <= dec_dis;
      look_way_q <= look_way;
    end
  end

  assign look_ent     = look_lines[int'(look_way_q)*ENT_W +: ENT_W];
  assign look_tag     = look_ent[TAG_W-1:0];
  assign look_valid   = look_ent[ENT_W-1];
  assign look_dirty   = look_ent[ENT_W-2];
  assign cache_en_clr = dis_q;

  AST_DIS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cache_en_clr |-> $past(addr_cmd_we || set_cmd_we)); // R13

  AST_NO_SEQ_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> busy); // R11
endmodule

// File: tb/cache_flush_ctrl_test.sv
module cache_flush_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 5;
  localparam int SET_W  = 5;
  localparam int WAYS   = 4;
  localparam int TAG_W  = ADDR_W - LINE_W - SET_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_cmd_we = 1'b0, set_cmd_we = 1'b0;
  logic [31:0] addr_cmd_data = '0, set_cmd_data = '0;
  logic fill_we = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [SET_W-1:0] fill_set = '0, look_set = '0;
  logic [1:0] fill_way = '0, look_way = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [TAG_W-1:0] look_tag;
  logic look_valid, look_dirty, busy, cache_en_clr, mem_req, mem_wr;
  logic [31:0] mem_addr;
  logic mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int log_n = 0;
  logic [31:0] log_addr [256];
  logic        log_wr   [256];
  logic last_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_flush_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W), .WAYS(WAYS)) uut (
    .clk(clk), .rst(rst),
    .addr_cmd_we(addr_cmd_we), .addr_cmd_data(addr_cmd_data),
    .set_cmd_we(set_cmd_we), .set_cmd_data(set_cmd_data),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
    .fill_valid(fill_valid), .fill_dirty(fill_dirty),
    .look_set(look_set), .look_way(look_way),
    .look_tag(look_tag), .look_valid(look_valid), .look_dirty(look_dirty),
    .busy(busy), .cache_en_clr(cache_en_clr),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_ack(mem_ack)
  );

  // memory stub: acknowledges each request two cycles after it appears, logs it
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          mem_ack = 1'b1;
          if (log_n < 256) begin
            log_addr[log_n] = mem_addr;
            log_wr[log_n]   = mem_wr;
          end
          log_n++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkaddr(input logic [TAG_W-1:0] t, input int s);
    return {t, 5'(s), 5'b0};
  endfunction

  function automatic logic [31:0] line_cmd(input int idx, input int way, input logic [1:0] m);
    return (32'(idx) << 16) | (32'(way) << 4) | 32'(m);
  endfunction

  function automatic logic [31:0] way_cmd(input logic [TAG_W-1:0] t, input bit fl, input bit v,
                                          input bit d, input int way, input logic [1:0] m);
    return {t, fl, v, d, 1'b0, 2'(way), 1'b0, 1'b1, m};
  endfunction

  task automatic fill(input int s, input int w, input logic [TAG_W-1:0] t, input bit v, input bit d);
    fill_set = 5'(s); fill_way = 2'(w); fill_tag = t; fill_valid = v; fill_dirty = d;
    fill_we = 1'b1;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic look(input int s, input int w);
    look_set = 5'(s); look_way = 2'(w);
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < WAYS; w++)
        fill(s, w, '0, 1'b0, 1'b0);
  endtask

  task automatic cmd_addr(input logic [31:0] d);
    log_n = 0;
    addr_cmd_data = d; addr_cmd_we = 1'b1;
    @(negedge clk);
    addr_cmd_we = 1'b0;
    last_clr = cache_en_clr;
  endtask

  task automatic cmd_set(input logic [31:0] d);
    log_n = 0;
    set_cmd_data = d; set_cmd_we = 1'b1;
    @(negedge clk);
    set_cmd_we = 1'b0;
    last_clr = cache_en_clr;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
    chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 0);
    chk(cache_en_clr == 1'b0, "R1 cache_en_clr", 64'(cache_en_clr), 0);
    fill(11, 2, 22'h2ABCD, 1'b1, 1'b0);
    look(11, 2);
    chk(look_tag == 22'h2ABCD && look_valid && !look_dirty, "R1 fill/look",
        64'({look_valid, look_dirty, look_tag}), 64'({2'b10, 22'h2ABCD}));
  endtask

  task automatic t_addr_line();
    fill(3, 2, 22'h11111, 1'b1, 1'b1);
    cmd_addr(mkaddr(22'h11111, 3) | 32'h3); wait_idle();
    chk(log_n == 1 && log_addr[0] == mkaddr(22'h11111, 3) && log_wr[0], "R2/R5 inv+wb request",
        64'(log_addr[0]), 64'(mkaddr(22'h11111, 3)));
    look(3, 2);
    chk(!look_valid && !look_dirty, "R2 inv+wb clears", 64'({look_valid, look_dirty}), 0);
    fill(3, 1, 22'h22222, 1'b1, 1'b1);
    cmd_addr(mkaddr(22'h22222, 3) | 32'h2); wait_idle();
    look(3, 1);
    chk(log_n == 1 && look_valid && !look_dirty, "R2 wb keeps valid",
        64'({log_n[7:0], look_valid, look_dirty}), 64'({8'd1, 2'b10}));
    fill(3, 0, 22'h33333, 1'b1, 1'b1);
    cmd_addr(mkaddr(22'h33333, 3) | 32'h1); wait_idle();
    look(3, 0);
    chk(log_n == 0 && !look_valid, "R2 inv no traffic", 64'({log_n[7:0], look_valid}), 0);
    fill(3, 3, 22'h04444, 1'b1, 1'b0);
    cmd_addr(mkaddr(22'h04444, 3) | 32'h2); wait_idle();
    chk(log_n == 0, "R5 clean line no write-back", 64'(log_n), 0);
  endtask

  task automatic t_miss();
    fill(6, 2, 22'h05555, 1'b1, 1'b1);
    cmd_addr(mkaddr(22'h05554, 6) | 32'h3); wait_idle();
    look(6, 2);
    chk(log_n == 0 && look_valid && look_dirty, "R3 miss leaves line",
        64'({log_n[7:0], look_valid, look_dirty}), 64'({8'd0, 2'b11}));
  endtask

  task automatic t_all();
    clear_all();
    fill(0, 2, 22'h0AAAA, 1'b1, 1'b1);
    fill(1, 3, 22'h0BBBB, 1'b1, 1'b1);
    fill(7, 0, 22'h0CCCC, 1'b1, 1'b1);
    fill(2, 1, 22'h0DDDD, 1'b1, 1'b0);
    cmd_addr(32'h7); wait_idle();
    chk(log_n == 3, "R4 all-lines write-back count", 64'(log_n), 3);
    chk(log_addr[0] == mkaddr(22'h0AAAA, 0) && log_addr[1] == mkaddr(22'h0BBBB, 1) &&
        log_addr[2] == mkaddr(22'h0CCCC, 7), "R4 order",
        {log_addr[0], log_addr[2]}, {mkaddr(22'h0AAAA, 0), mkaddr(22'h0CCCC, 7)});
    look(2, 1);
    chk(!look_valid, "R4 clean line invalidated", 64'(look_valid), 0);
    look(7, 0);
    chk(!look_valid && !look_dirty, "R4 dirty line invalidated", 64'({look_valid, look_dirty}), 0);
  endtask

  task automatic t_set_line();
    fill(5, 1, 22'h06666, 1'b1, 1'b1);
    fill(5, 0, 22'h06667, 1'b1, 1'b1);
    cmd_set(line_cmd(5, 1, 2'b10)); wait_idle();
    chk(log_n == 1 && log_addr[0] == mkaddr(22'h06666, 5), "R6 line write-back",
        64'(log_addr[0]), 64'(mkaddr(22'h06666, 5)));
    look(5, 1);
    chk(look_valid && !look_dirty, "R6 valid kept", 64'({look_valid, look_dirty}), 64'(2'b10));
    look(5, 0);
    chk(look_valid && look_dirty, "R6 other way untouched", 64'({look_valid, look_dirty}), 64'(2'b11));
    fill(5, 2, 22'h06668, 1'b1, 1'b1);
    cmd_set(line_cmd(5, 2, 2'b01)); wait_idle();
    look(5, 2);
    chk(log_n == 0 && !look_valid, "R6 line invalidate", 64'({log_n[7:0], look_valid}), 0);
  endtask

  task automatic t_way_load();
    cmd_set(way_cmd(22'h1F00F, 1'b0, 1'b1, 1'b1, 3, 2'b01)); wait_idle();
    chk(log_n == 0, "R7 load no traffic", 64'(log_n), 0);
    look(0, 3);
    chk(look_tag == 22'h1F00F && look_valid && look_dirty, "R7 set 0",
        64'({look_valid, look_dirty, look_tag}), 64'({2'b11, 22'h1F00F}));
    look(31, 3);
    chk(look_tag == 22'h1F00F && look_valid && look_dirty, "R7 set 31",
        64'({look_valid, look_dirty, look_tag}), 64'({2'b11, 22'h1F00F}));
    look(5, 0);
    chk(look_tag == 22'h06667 && look_valid, "R7 other way kept", 64'(look_tag), 64'(22'h06667));
  endtask

  task automatic t_way_wb_load();
    cmd_set(way_cmd(22'h2E0E0, 1'b0, 1'b1, 1'b0, 3, 2'b11)); wait_idle();
    chk(log_n == 32 && log_wr[0], "R8 write-back count", 64'(log_n), 32);
    chk(log_addr[0] == mkaddr(22'h1F00F, 0) && log_addr[31] == mkaddr(22'h1F00F, 31),
        "R8 old contents written back", {log_addr[0], log_addr[31]},
        {mkaddr(22'h1F00F, 0), mkaddr(22'h1F00F, 31)});
    look(12, 3);
    chk(look_tag == 22'h2E0E0 && look_valid && !look_dirty, "R8 new contents loaded",
        64'({look_valid, look_dirty, look_tag}), 64'({2'b10, 22'h2E0E0}));
    cmd_set(way_cmd(22'h0, 1'b0, 1'b0, 1'b0, 3, 2'b10)); wait_idle();
    chk(log_n == 0, "R8 way write-back skips clean lines", 64'(log_n), 0);
  endtask

  task automatic t_fetch();
    cmd_set(way_cmd(22'h3A5A5, 1'b1, 1'b1, 1'b0, 0, 2'b01)); wait_idle();
    chk(log_n == 32 && !log_wr[0] && !log_wr[31], "R9 fetch count/direction",
        64'({log_n[7:0], log_wr[0]}), 64'({8'd32, 1'b0}));
    chk(log_addr[5] == mkaddr(22'h3A5A5, 5), "R9 fetch address", 64'(log_addr[5]),
        64'(mkaddr(22'h3A5A5, 5)));
    look(5, 0);
    chk(look_tag == 22'h3A5A5 && look_valid, "R9 line loaded", 64'(look_tag), 64'(22'h3A5A5));
  endtask

  task automatic t_ack_order();
    int guard = 0;
    fill(4, 1, 22'h07777, 1'b1, 1'b1);
    look(4, 1);
    cmd_addr(mkaddr(22'h07777, 4) | 32'h3);
    while (!mem_req && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(mem_req && look_valid && look_dirty, "R10 bits held until ack",
        64'({mem_req, look_valid, look_dirty}), 64'(3'b111));
    wait_idle();
    look(4, 1);
    chk(!look_valid && !look_dirty, "R10 cleared after ack", 64'({look_valid, look_dirty}), 0);
  endtask

  task automatic t_busy();
    clear_all();
    fill(9, 2, 22'h09999, 1'b1, 1'b0);
    fill(0, 0, 22'h01234, 1'b1, 1'b1);
    cmd_addr(32'h6);
    chk(busy == 1'b1, "R11 busy after accept", 64'(busy), 1);
    cmd_set(line_cmd(9, 2, 2'b01));
    fill(10, 1, 22'h05A5A, 1'b1, 1'b1);
    cmd_addr(32'h8);
    chk(last_clr == 1'b1, "R13 disable while busy", 64'(last_clr), 1);
    wait_idle();
    chk(busy == 1'b0, "R11 busy falls", 64'(busy), 0);
    look(9, 2);
    chk(look_valid == 1'b1, "R11 command while busy ignored", 64'(look_valid), 1);
    look(10, 1);
    chk(look_valid == 1'b0, "R11 fill while busy ignored", 64'(look_valid), 0);
    look(0, 0);
    chk(look_valid && !look_dirty, "R11 running flush completed", 64'({look_valid, look_dirty}), 64'(2'b10));
  endtask

  task automatic t_nop();
    fill(8, 0, 22'h08888, 1'b1, 1'b1);
    cmd_addr(mkaddr(22'h08888, 8));
    chk(busy == 1'b0, "R12 addr mode 000", 64'(busy), 0);
    cmd_addr(mkaddr(22'h08888, 8) | 32'h4);
    chk(busy == 1'b0, "R12 addr mode 100", 64'(busy), 0);
    cmd_set(line_cmd(8, 0, 2'b00));
    chk(busy == 1'b0, "R12 set mode 00", 64'(busy), 0);
    cmd_set(way_cmd(22'h0, 1'b0, 1'b0, 1'b0, 0, 2'b00));
    chk(busy == 1'b0, "R12 way mode 00", 64'(busy), 0);
    repeat (4) @(negedge clk);
    look(8, 0);
    chk(log_n == 0 && look_valid && look_dirty, "R12 line unchanged",
        64'({log_n[7:0], look_valid, look_dirty}), 64'({8'd0, 2'b11}));
  endtask

  task automatic t_disable();
    cmd_addr(32'h8);
    chk(last_clr == 1'b1, "R13 address port pulse", 64'(last_clr), 1);
    @(negedge clk);
    chk(cache_en_clr == 1'b0, "R13 pulse one cycle", 64'(cache_en_clr), 0);
    cmd_set(32'h8);
    chk(last_clr == 1'b1, "R13 set port pulse", 64'(last_clr), 1);
    cmd_set(32'h0);
    chk(last_clr == 1'b0, "R13 no pulse without bit", 64'(last_clr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    clear_all();
    t_addr_line();
    t_miss();
    t_all();
    t_set_line();
    t_way_load();
    t_way_wb_load();
    t_fetch();
    t_ack_order();
    t_busy();
    t_nop();
    t_disable();
    finish_run();
  end
endmodule